// File: doc/BRIEF.md
# I2C Register-Bank Slave with Pointer Autoincrement

This block is an I2C target that lets an external bus master read and write a bank of 128 eight-bit registers held inside the block. SCL and SDA arrive from open-drain pads and are sampled in the system clock domain. The block never drives SDA high. It only pulls the line low through an output enable, and the pad logic outside the block turns that enable into a low-side driver.

A transfer begins with a START and an address byte. The upper seven bits of that byte must equal the device address parameter, and its lowest bit selects read (1) or write (0). In a write transfer, the first byte after the address is a sub-address. Its low seven bits load the register pointer, and its top bit decides whether the pointer steps forward after each data byte for the rest of the transfer. The bytes that follow are stored at the pointer. To read, the master sets the pointer with a short write, issues a repeated START, and sends the address with the read bit set. The block then returns bytes from the pointer for as long as the master acknowledges them.

The pointer and the autoincrement setting persist across transfers. With autoincrement on, the pointer wraps from 127 to 0.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A falling SDA while SCL is high (START or repeated START) restarts address reception in any state. A rising SDA while SCL is high (STOP) returns the block to idle. After either one, sda_oe is 0.
- R2: An address byte is sent MSB first. Its bits 7..1 are the device address and bit 0 is the R/W flag (1 = read). If bits 7..1 match SLAVE_ADDR, sda_oe is 1 throughout the high phase of the ninth clock. If they do not match, sda_oe stays 0 for that slot and for every later bit until the next START.
- R3: In a write transfer, the first byte after the address is the sub-address. Bits 6..0 load the register pointer and bit 7 sets autoincrement (1 = on). The byte is acknowledged.
- R4: Each data byte written after the sub-address is stored in the register the pointer selects, and it is acknowledged.
- R5: With autoincrement on, the pointer advances by one after each data byte written or read. With autoincrement off, it stays fixed, so repeated writes overwrite one register and repeated reads return the same value.
- R6: After a repeated START and a matching address with R/W = 1, the block sends the register at the pointer MSB first. sda_oe = 1 sends a 0 bit and sda_oe = 0 sends a 1 bit.
- R7: During a read, a master ACK (SDA low on the ninth clock) makes the block send the next byte. A master NACK makes the block keep SDA released on every later clock until a START or STOP.
- R8: With autoincrement on, the pointer wraps from 127 to 0 for both writes and reads.
- R9: sda_oe changes only in response to an SCL falling edge, a START or a STOP. It never changes while SCL stays high.
- R10: After reset, every register reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level sampled from the pad |
| sda_i | input | 1 | SDA level sampled from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest situation to reach from the pins is the window after a master NACK. In that window the block must stay silent while SCL keeps toggling, and no START or STOP arrives to reset it. The bench reads a single byte with a NACK, then sends nine more SCL pulses with SDA released, and checks during each high phase that the line stays high. A second hard case is a repeated START that cuts a write short just after the sub-address. The bench then checks that only the byte from the new transfer landed in the bank. Pointer wrap is reached by bursting across register 127, in both the write and the read direction.

// File: rtl/i2c_rb_pkg.sv
// Package: shared constants and the protocol state type for the I2C register-bank slave.
// Assumes byte-wide transfers as fixed by the bus protocol.
package i2c_rb_pkg;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring the bus until START
        ST_ADDR,   // shifting in the address byte
        ST_SUB,    // shifting in the sub-address byte
        ST_WDATA,  // shifting in a write data byte
        ST_ACK,    // holding SDA low for the ninth clock
        ST_RDATA,  // shifting out a read data byte
        ST_RACK    // sampling the master acknowledge
    } proto_st_t;
endpackage

// File: rtl/i2c_rb_line_sync.sv
// Module: brings SCL and SDA into the clock domain through a flop chain and
// derives SCL edges plus START/STOP events from the synchronized levels.
// Assumes the system clock is several times faster than SCL. The lines reset high (idle bus).
module i2c_rb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pad,
    input  logic sda_pad,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0]  pad_in;
    logic [LINES-1:0]  sync_out;
    logic [LINES-1:0]  prev_q;

    assign pad_in = {scl_pad, sda_pad};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        // Shift one pad level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pad_in[g]};
        end
        assign sync_out[g] = chain_q[STAGES-1];
    end

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= sync_out;
    end

    assign scl_lvl   = sync_out[1];
    assign sda_lvl   = sync_out[0];
    assign scl_rise  = sync_out[1] & ~prev_q[1];
    assign scl_fall  = ~sync_out[1] & prev_q[1];
    assign start_det = sync_out[1] & prev_q[1] & prev_q[0] & ~sync_out[0];
    assign stop_det  = sync_out[1] & prev_q[1] & ~prev_q[0] & sync_out[0];
endmodule

// File: rtl/i2c_rb_regfile.sv
// Module: register bank with one synchronous write port and one combinational read port.
// Assumes at most one write per cycle. All entries clear to zero on reset.
module i2c_rb_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise store the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the addressed entry without a pipeline stage.
    always_comb rd_data = mem_q[rd_addr];
endmodule

// File: rtl/i2c_regbank_slave.sv
// Module: I2C target with a 7-bit address, a sub-address pointer with optional
// autoincrement, and burst reads and writes into an internal register bank.
// Assumes open-drain pads: sda_oe = 1 pulls SDA low. No clock stretching.
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
    parameter int         PTR_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    proto_st_t            state, ack_next;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] rx_sr, tx_sr, rd_data;
    logic [PTR_W-1:0]     ptr;
    logic                 auto_inc, mack;
    logic                 rx_done, addr_hit, sub_load, wr_en, tx_load, ptr_adv;

    i2c_rb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_pad(scl_i), .sda_pad(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rb_regfile #(.ADDR_W(PTR_W), .DATA_W(BYTE_BITS)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
        .wr_data(rx_sr), .rd_addr(ptr), .rd_data(rd_data)
    );

    // Decode the byte-boundary events that move the pointer or touch the bank.
    always_comb begin
        rx_done  = scl_fall && (bit_cnt == CNT_W'(BYTE_BITS));
        addr_hit = (rx_sr[7:1] == SLAVE_ADDR);
        sub_load = (state == ST_SUB) && rx_done;
        wr_en    = (state == ST_WDATA) && rx_done;
        tx_load  = scl_fall && (((state == ST_ACK) && (ack_next == ST_RDATA)) ||
                                ((state == ST_RACK) && mack));
        ptr_adv  = wr_en || tx_load;
    end

    // Keep the register pointer and the autoincrement mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            auto_inc <= 1'b0;
        end else if (sub_load) begin
            ptr      <= rx_sr[PTR_W-1:0];
            auto_inc <= rx_sr[BYTE_BITS-1];
        end else if (ptr_adv && auto_inc) begin
            ptr      <= ptr + PTR_W'(1);
        end
    end

    // Protocol sequencer: shift bits, acknowledge, and drive read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '1;
            sda_oe   <= 1'b0;
            mack     <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (scl_rise) begin
                        rx_sr   <= {rx_sr[BYTE_BITS-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (rx_done) begin
                        bit_cnt <= '0;
                        if ((state == ST_ADDR) && !addr_hit) begin
                            state <= ST_IDLE;
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK;
                            if (state == ST_ADDR) ack_next <= rx_sr[0] ? ST_RDATA : ST_SUB;
                            else                  ack_next <= ST_WDATA;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        state   <= ack_next;
                        if (ack_next == ST_RDATA) begin
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_BITS-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (rx_done) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        state   <= ST_RACK;
                    end else if (scl_fall) begin
                        tx_sr  <= {tx_sr[BYTE_BITS-2:0], 1'b1};
                        sda_oe <= ~tx_sr[BYTE_BITS-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx_sr  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_BITS-1];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Checks on bus conditions, acknowledge drive and pointer movement.
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR) && (bit_cnt == '0) && !sda_oe); // R1
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE) && !sda_oe); // R1
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> sda_oe); // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && auto_inc) |=> ptr == $past(ptr) + PTR_W'(1)); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_adv && !auto_inc) |=> $stable(ptr)); // R5
    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe)); // R9
endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
// Bench: a bus-master driver pushes expected read bytes into a scoreboard queue,
// and a monitor pops each one and compares it with the byte the master observes.
module i2c_regbank_slave_tb_top;
    localparam logic [6:0] DEV_ADDR = 7'h3A;
    localparam int Q = 8;   // clock cycles per quarter SCL period

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    exp_t exp_q[$];
    logic [7:0] rd_byte;
    event rd_done;
    logic [7:0] model [128];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regbank_slave #(.SLAVE_ADDR(DEV_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // Send one byte; ack is 1 only if SDA was low at both ends of the ninth high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a0, a1;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1);
        a0 = ~sda_line;
        tick(2 * Q - 2);
        a1 = ~sda_line;
        tick(1);
        scl_m = 1'b0; tick(Q);
        ack = a0 & a1;
    endtask

    // Receive one byte, then drive the master acknowledge.
    task automatic recv_byte(input bit give_ack);
        logic [7:0] d;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            d[i] = sda_line;
            tick(Q);
            scl_m = 1'b0;
        end
        tick(1);
        rd_byte = d;
        ->rd_done;
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q - 1);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // Write transfer of n bytes starting at base; the model follows R4/R5/R8.
    task automatic wr_txn(input logic [7:0] sub, input int n, input logic [7:0] base);
        bit ack;
        logic [6:0] p = sub[6:0];
        bus_start();
        send_byte({DEV_ADDR, 1'b0}, ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(sub, ack);
        chk(ack, "R3 sub-address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(base + 8'(i), ack);
            chk(ack, "R4 data ack", ack, 1);
            model[p] = base + 8'(i);
            if (sub[7]) p = p + 7'd1;
        end
        bus_stop();
    endtask

    // Read transfer: set the pointer, repeated START, then n bytes (NACK on the last).
    task automatic rd_txn(input logic [7:0] sub, input int n, input string req);
        bit ack;
        logic [6:0] p = sub[6:0];
        exp_t e;
        for (int i = 0; i < n; i++) begin
            e.val = model[p];
            e.req = req;
            exp_q.push_back(e);
            if (sub[7]) p = p + 7'd1;
        end
        bus_start();
        send_byte({DEV_ADDR, 1'b0}, ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(sub, ack);
        chk(ack, "R3 sub-address ack", ack, 1);
        bus_start();
        send_byte({DEV_ADDR, 1'b1}, ack);
        chk(ack, "R6 read address ack", ack, 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1);
        bus_stop();
    endtask

    // Scoreboard monitor: compare each observed read byte with the queued expectation.
    initial begin
        exp_t e;
        forever begin
            @(rd_done);
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected read byte", rd_byte, 0);
            end else begin
                e = exp_q.pop_front();
                chk(rd_byte === e.val, e.req, rd_byte, e.val);
            end
        end
    end

    // R9 monitor: flag any sda_oe change while SCL stays high.
    initial begin
        logic prev_oe = 1'b0;
        logic prev_scl = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) oe_viol++;
            prev_oe = sda_oe;
            prev_scl = scl_m;
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(10);
        chk(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

        // R10: an unwritten register reads zero.
        rd_txn(8'h05, 1, "R10 reset value");

        // R8/R5: autoincrement write burst across the top of the bank.
        wr_txn(8'hFE, 3, 8'hA1);
        rd_txn(8'hFE, 3, "R8 wrap read burst");

        // R5: fixed pointer write overwrites one register, neighbour untouched.
        wr_txn(8'h10, 2, 8'h55);
        rd_txn(8'h90, 2, "R5 fixed-pointer write");
        rd_txn(8'h10, 3, "R5 fixed-pointer read repeats");

        // R2: wrong address is ignored until the next START.
        bus_start();
        send_byte({7'h3B, 1'b0}, ack);
        chk(!ack, "R2 mismatch not acked", ack, 0);
        send_byte(8'hA0, ack);
        chk(!ack, "R2 ignored sub-address", ack, 0);
        send_byte(8'hEE, ack);
        chk(!ack, "R2 ignored data", ack, 0);
        bus_stop();
        rd_txn(8'h20, 1, "R2 ignored write left register");

        // R7: after NACK the line stays released on further clocks.
        exp_q.push_back('{val: model[7'h7F], req: "R7 single read before NACK"});
        bus_start();
        send_byte({DEV_ADDR, 1'b0}, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte({DEV_ADDR, 1'b1}, ack);
        recv_byte(1'b0);
        begin
            int low_seen = 0;
            for (int k = 0; k < 9; k++) begin
                tick(Q);
                scl_m = 1'b1; tick(Q);
                if (!sda_line) low_seen++;
                tick(Q);
                scl_m = 1'b0; tick(Q);
            end
            chk(low_seen == 0, "R7 released after NACK", low_seen, 0);
        end
        bus_stop();

        // R1: repeated START cuts a write short after the sub-address.
        bus_start();
        send_byte({DEV_ADDR, 1'b0}, ack);
        send_byte(8'h30, ack);
        bus_start();
        send_byte({DEV_ADDR, 1'b0}, ack);
        chk(ack, "R1 address after repeated START", ack, 1);
        send_byte(8'h31, ack);
        send_byte(8'h77, ack);
        chk(ack, "R4 data after repeated START", ack, 1);
        model[7'h31] = 8'h77;
        bus_stop();
        chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);
        rd_txn(8'hB0, 2, "R1 only new transfer stored");

        tick(4 * Q);
        chk(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
        chk(oe_viol == 0, "R9 no sda_oe change with SCL high", oe_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule